// File: doc/BRIEF.md
# Flash Sector Lock-State Scanner

This block walks one bank of a parallel NOR flash of the AMD command-set family and finds out, sector by sector, whether each sector is write-protected. It drives the flash through a 16-bit bus master port with one access in flight at a time. The bank layout comes from a small table of groups that sits on input pins. Each table entry holds a block count, a block size in bytes and two flags. One flag says the group opens a flash partition and the other says it closes one. The scan visits the groups in table order. When a group opens a partition, the block first puts that partition into identification mode. It then reads one protection word per block. When a group closes a partition, it writes the partition back to read mode after the group's last block.

Each block that is read produces one record on an output stream: the block's byte offset within the bank and its lock bit. The record stream is valid/ready. While a record is offered and not taken, the record holds its value and the scan does not move on. No bus access starts while a record waits. The bus request channel follows the same rule. Address, data and direction stay fixed from the cycle `bus_req_valid` rises until the cycle `bus_req_ready` is seen. A response is accepted only after the request has been accepted.

A one-cycle `start` launches a scan. A one-cycle `done` ends it, together with a pass flag and an error flag. In check mode every lock bit is compared with a requested value. The first difference closes the current partition and ends the scan as failed.

Top module: `flash_lock_scanner`

## Requirements
- R1: After reset and between scans, `bus_req_valid`, `rec_valid` and `done` are low. A `start` seen while idle begins a scan. Every scan ends with exactly one `done` cycle in which `done_pass` and `done_err` are never both high.
- R2: At a group whose partition-open flag is set, the block issues three writes before the group's first read. The writes are 16'h00AA to P+0xAAA, then 16'h0055 to P+0x554, then 16'h0090 to P+0xAAA. P is `base_addr` plus the current offset, and it stays the partition base until the next opening group. No group without this flag causes these writes.
- R3: Each block is probed with one read (`bus_req_write`=0) at `base_addr` + offset + 4. The record reports that offset, and `rec_locked` is bit 0 of the read data. All other data bits are ignored.
- R4: The offset starts at 0 for every scan. It grows by the group's block size after each block. Groups 0 to `grp_used`-1 are visited in index order, and group g takes bits [g*W +: W] of the packed table buses.
- R5: After the last block of a group whose partition-close flag is set, the block writes 16'h00F0 to P+0xAAA. This reset is the only write between that group's last read and the next group's accesses, and a group without the flag produces no such write.
- R6: While `rec_valid` is high and `rec_ready` is low, `rec_offset` and `rec_locked` stay stable and no bus request is issued.
- R7: Only one bus access is outstanding at a time. A request is held stable until it is accepted, and no new request starts until a response has arrived.
- R8: In check mode (`verify_en`=1 at `start`), the block compares each record's lock bit with `verify_target`. At the first difference it emits that record, writes 16'h00F0 to P+0xAAA, and ends with `done_pass`=0 and `done_err`=0. It makes no further reads.
- R9: A check-mode scan whose lock bits all equal the target, and any plain scan without bus error, ends with `done_pass`=1.
- R10: A response with `bus_rsp_err`=1 ends the scan in the next cycle with `done`=1, `done_err`=1 and `done_pass`=0. No record is produced for that access, and no further bus request follows.
- R11: A `start` pulse during a running scan is ignored. The access sequence and the records are those of a single scan.
- R12: A group with a block count of 0 produces no read and no record. Its flags still cause the entry writes and the reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle scan launch, taken only when idle |
| verify_en | input | 1 | Check mode select, sampled with `start` |
| verify_target | input | 1 | Lock value expected in check mode, sampled with `start` |
| base_addr | input | ADDR_W | Byte address of the bank in the bus space |
| grp_used | input | GRP_W | Number of table entries to walk |
| grp_count | input | NGRP*CNT_W | Packed block counts, group g at [g*CNT_W +: CNT_W] |
| grp_size | input | NGRP*ADDR_W | Packed block sizes in bytes, group g at [g*ADDR_W +: ADDR_W] |
| grp_open | input | NGRP | Partition-open flag per group |
| grp_close | input | NGRP | Partition-close flag per group |
| bus_req_valid | output | 1 | Bus request offered |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_addr | output | ADDR_W | Bus byte address |
| bus_req_wdata | output | 16 | Bus write data |
| bus_req_write | output | 1 | 1 for write, 0 for read |
| bus_rsp_valid | input | 1 | Bus response (read data or write acknowledge) |
| bus_rsp_rdata | input | 16 | Bus read data |
| bus_rsp_err | input | 1 | Bus error flag, meaningful with `bus_rsp_valid` |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Record accepted |
| rec_offset | output | ADDR_W | Byte offset of the block within the bank |
| rec_locked | output | 1 | 1 when the block is write-protected |
| done | output | 1 | One-cycle end of scan |
| done_pass | output | 1 | Scan completed without mismatch or error |
| done_err | output | 1 | Scan aborted by a bus error |

## Verification
A wrong group index, offset or partition base shows up on the bus within a few cycles. The next read lands at the wrong address, or the entry or reset writes go to the wrong base or are missing. The bench catches this by comparing the full logged access sequence with one computed from the table. A stale lock bit or a wrong offset register shows in the record that follows the read. A check-mode or error path that fails to stop shows as extra reads after the mismatch or error response, or as a `done` that arrives late or with the wrong flags.

// File: rtl/flb_pkg.sv
package flb_pkg;

  localparam logic [15:0] CMD_UNLOCK_1 = 16'h00AA;
  localparam logic [15:0] CMD_UNLOCK_2 = 16'h0055;
  localparam logic [15:0] CMD_ID_ENTER = 16'h0090;
  localparam logic [15:0] CMD_READ_RET = 16'h00F0;

  localparam int unsigned OFS_CMD_A   = 32'h0000_0AAA;
  localparam int unsigned OFS_CMD_B   = 32'h0000_0554;
  localparam int unsigned OFS_PROT_WD = 32'h0000_0004;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_GROUP,
    SC_ENTRY,
    SC_BLOCK,
    SC_READ,
    SC_RECORD,
    SC_RESET
  } scan_st_e;

  typedef enum logic [1:0] {
    BP_IDLE,
    BP_REQ,
    BP_WAIT
  } bus_st_e;

endpackage

// File: rtl/flb_group_sel.sv
module flb_group_sel #(
  parameter int ADDR_W = 24,
  parameter int NGRP   = 4,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 3
) (
  input  logic [GRP_W-1:0]       idx,
  input  logic [NGRP*CNT_W-1:0]  tbl_count,
  input  logic [NGRP*ADDR_W-1:0] tbl_size,
  input  logic [NGRP-1:0]        tbl_open,
  input  logic [NGRP-1:0]        tbl_close,
  output logic [CNT_W-1:0]       sel_count,
  output logic [ADDR_W-1:0]      sel_size,
  output logic                   sel_open,
  output logic                   sel_close
);

  localparam int IDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic [CNT_W-1:0]  cnt_arr  [NGRP];
  logic [ADDR_W-1:0] size_arr [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_unpack
    assign cnt_arr[g]  = tbl_count[g*CNT_W +: CNT_W];
    assign size_arr[g] = tbl_size[g*ADDR_W +: ADDR_W];
  end

  logic [IDX_W-1:0] idx_n;
  logic             in_range;
  assign idx_n    = IDX_W'(idx);
  assign in_range = (int'(idx) < NGRP);

  always_comb begin
    if (in_range) begin
      sel_count = cnt_arr[idx_n];
      sel_size  = size_arr[idx_n];
      sel_open  = tbl_open[idx_n];
      sel_close = tbl_close[idx_n];
    end else begin
      sel_count = '0;
      sel_size  = '0;
      sel_open  = 1'b0;
      sel_close = 1'b0;
    end
  end

endmodule

// File: rtl/flb_bus_port.sv
module flb_bus_port
  import flb_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_go,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [15:0]       acc_wdata,
  input  logic              acc_write,
  output logic              acc_done,
  output logic              acc_err,
  output logic [15:0]       acc_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [15:0]       bus_req_wdata,
  output logic              bus_req_write,
  input  logic              bus_rsp_valid,
  input  logic [15:0]       bus_rsp_rdata,
  input  logic              bus_rsp_err
);

  bus_st_e st;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      case (st)
        BP_IDLE: if (acc_go) begin
          addr_q  <= acc_addr;
          wdata_q <= acc_wdata;
          write_q <= acc_write;
          st      <= BP_REQ;
        end
        BP_REQ:  if (bus_req_ready) st <= BP_WAIT;
        BP_WAIT: if (bus_rsp_valid) st <= BP_IDLE;
        default: st <= BP_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (st == BP_REQ);
  assign bus_req_addr  = addr_q;
  assign bus_req_wdata = wdata_q;
  assign bus_req_write = write_q;
  assign acc_done      = (st == BP_WAIT) && bus_rsp_valid;
  assign acc_err       = bus_rsp_err;
  assign acc_rdata     = bus_rsp_rdata;

  // R7: a new access is only requested while the port has nothing in flight
  p_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |-> (st == BP_IDLE));

  // R7: an offered request stays offered and unchanged until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata)
       && $stable(bus_req_write)));

endmodule

// File: rtl/flb_rec_out.sv
module flb_rec_out #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_offset,
  input  logic              load_locked,
  output logic              taken,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [ADDR_W-1:0] rec_offset,
  output logic              rec_locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid  <= 1'b0;
      rec_offset <= '0;
      rec_locked <= 1'b0;
    end else if (load) begin
      rec_valid  <= 1'b1;
      rec_offset <= load_offset;
      rec_locked <= load_locked;
    end else if (taken) begin
      rec_valid  <= 1'b0;
    end
  end

  assign taken = rec_valid && rec_ready;

  // R6: a stalled record keeps its contents
  p_rec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=>
      (rec_valid && $stable(rec_offset) && $stable(rec_locked)));

endmodule

// File: rtl/flash_lock_scanner.sv
module flash_lock_scanner
  import flb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NGRP   = 4,
  parameter int CNT_W  = 8,
  localparam int GRP_W = $clog2(NGRP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   verify_en,
  input  logic                   verify_target,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic [GRP_W-1:0]       grp_used,
  input  logic [NGRP*CNT_W-1:0]  grp_count,
  input  logic [NGRP*ADDR_W-1:0] grp_size,
  input  logic [NGRP-1:0]        grp_open,
  input  logic [NGRP-1:0]        grp_close,
  output logic                   bus_req_valid,
  input  logic                   bus_req_ready,
  output logic [ADDR_W-1:0]      bus_req_addr,
  output logic [15:0]            bus_req_wdata,
  output logic                   bus_req_write,
  input  logic                   bus_rsp_valid,
  input  logic [15:0]            bus_rsp_rdata,
  input  logic                   bus_rsp_err,
  output logic                   rec_valid,
  input  logic                   rec_ready,
  output logic [ADDR_W-1:0]      rec_offset,
  output logic                   rec_locked,
  output logic                   done,
  output logic                   done_pass,
  output logic                   done_err
);

  localparam logic [ADDR_W-1:0] A_CMD_A = ADDR_W'(OFS_CMD_A);
  localparam logic [ADDR_W-1:0] A_CMD_B = ADDR_W'(OFS_CMD_B);
  localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(OFS_PROT_WD);

  scan_st_e          state;
  logic [GRP_W-1:0]  grp_idx;
  logic [CNT_W-1:0]  blk_cnt;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] part_base;
  logic [1:0]        step;
  logic              issued;
  logic              fail_flag;
  logic              locked_q;
  logic              verify_q;
  logic              target_q;

  logic [CNT_W-1:0]  g_count;
  logic [ADDR_W-1:0] g_size;
  logic              g_open;
  logic              g_close;

  logic              acc_go;
  logic [ADDR_W-1:0] acc_addr;
  logic [15:0]       acc_wdata;
  logic              acc_write;
  logic              acc_done;
  logic              acc_err;
  logic [15:0]       acc_rdata;
  logic              rec_load;
  logic              rec_taken;
  logic              rd_unused_bits;

  assign rd_unused_bits = ^acc_rdata[15:1];

  flb_group_sel #(
    .ADDR_W(ADDR_W), .NGRP(NGRP), .CNT_W(CNT_W), .GRP_W(GRP_W)
  ) u_gsel (
    .idx       (grp_idx),
    .tbl_count (grp_count),
    .tbl_size  (grp_size),
    .tbl_open  (grp_open),
    .tbl_close (grp_close),
    .sel_count (g_count),
    .sel_size  (g_size),
    .sel_open  (g_open),
    .sel_close (g_close)
  );

  // access selection: what the current state puts on the bus
  always_comb begin
    acc_addr  = part_base + A_CMD_A;
    acc_wdata = CMD_READ_RET;
    acc_write = 1'b1;
    case (state)
      SC_ENTRY: begin
        case (step)
          2'd0:    begin acc_addr = part_base + A_CMD_A; acc_wdata = CMD_UNLOCK_1; end
          2'd1:    begin acc_addr = part_base + A_CMD_B; acc_wdata = CMD_UNLOCK_2; end
          default: begin acc_addr = part_base + A_CMD_A; acc_wdata = CMD_ID_ENTER; end
        endcase
      end
      SC_READ: begin
        acc_addr  = base_addr + offset + A_PROT;
        acc_wdata = 16'h0000;
        acc_write = 1'b0;
      end
      default: ;
    endcase
  end

  assign acc_go = !issued &&
                  ((state == SC_ENTRY) || (state == SC_READ) || (state == SC_RESET));

  flb_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_go        (acc_go),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .acc_write     (acc_write),
    .acc_done      (acc_done),
    .acc_err       (acc_err),
    .acc_rdata     (acc_rdata),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_req_write (bus_req_write),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_rdata (bus_rsp_rdata),
    .bus_rsp_err   (bus_rsp_err)
  );

  assign rec_load = (state == SC_READ) && acc_done && !acc_err;

  flb_rec_out #(.ADDR_W(ADDR_W)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (rec_load),
    .load_offset (offset),
    .load_locked (acc_rdata[0]),
    .taken       (rec_taken),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_offset  (rec_offset),
    .rec_locked  (rec_locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SC_IDLE;
      grp_idx   <= '0;
      blk_cnt   <= '0;
      offset    <= '0;
      part_base <= '0;
      step      <= '0;
      issued    <= 1'b0;
      fail_flag <= 1'b0;
      locked_q  <= 1'b0;
      verify_q  <= 1'b0;
      target_q  <= 1'b0;
      done      <= 1'b0;
      done_pass <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done      <= 1'b0;
      done_pass <= 1'b0;
      done_err  <= 1'b0;
      if (acc_go)        issued <= 1'b1;
      else if (acc_done) issued <= 1'b0;

      if (acc_done && acc_err) begin
        state    <= SC_IDLE;
        done     <= 1'b1;
        done_err <= 1'b1;
      end else begin
        case (state)
          SC_IDLE: if (start) begin
            verify_q  <= verify_en;
            target_q  <= verify_target;
            grp_idx   <= '0;
            offset    <= '0;
            part_base <= base_addr;
            fail_flag <= 1'b0;
            state     <= SC_GROUP;
          end
          SC_GROUP: begin
            blk_cnt <= '0;
            if (grp_idx >= grp_used) begin
              done      <= 1'b1;
              done_pass <= 1'b1;
              state     <= SC_IDLE;
            end else if (g_open) begin
              part_base <= base_addr + offset;
              step      <= '0;
              state     <= SC_ENTRY;
            end else begin
              state <= SC_BLOCK;
            end
          end
          SC_ENTRY: if (acc_done) begin
            if (step == 2'd2) state <= SC_BLOCK;
            else              step  <= step + 2'd1;
          end
          SC_BLOCK: begin
            if (blk_cnt == g_count) begin
              if (g_close) begin
                state <= SC_RESET;
              end else begin
                grp_idx <= grp_idx + 1'b1;
                state   <= SC_GROUP;
              end
            end else begin
              state <= SC_READ;
            end
          end
          SC_READ: if (acc_done) begin
            locked_q <= acc_rdata[0];
            state    <= SC_RECORD;
          end
          SC_RECORD: if (rec_taken) begin
            if (verify_q && (locked_q != target_q)) begin
              fail_flag <= 1'b1;
              state     <= SC_RESET;
            end else begin
              offset  <= offset + g_size;
              blk_cnt <= blk_cnt + 1'b1;
              state   <= SC_BLOCK;
            end
          end
          SC_RESET: if (acc_done) begin
            if (fail_flag) begin
              done  <= 1'b1;
              state <= SC_IDLE;
            end else begin
              grp_idx <= grp_idx + 1'b1;
              state   <= SC_GROUP;
            end
          end
          default: state <= SC_IDLE;
        endcase
      end
    end
  end

  // R1: pass and error never reported together
  p_done_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(done_pass && done_err));

  // R1: no bus traffic while the sequencer is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_IDLE) |-> !bus_req_valid);

  // R10: an error response ends the scan one cycle later
  p_err_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && acc_err) |=> (done && done_err && !done_pass));

  // R6: no bus request while a record waits
  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |-> !acc_go);

endmodule

// File: tb/flash_lock_scanner_test.sv
module flash_lock_scanner_test;

  localparam int ADDR_W = 24;
  localparam int NGRP   = 4;
  localparam int CNT_W  = 8;
  localparam int GRP_W  = $clog2(NGRP + 1);
  localparam logic [ADDR_W-1:0] BASE = 24'h20_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0, verify_en = 1'b0, verify_target = 1'b0;
  logic [GRP_W-1:0] grp_used = '0;
  logic [CNT_W-1:0]  cfg_cnt  [NGRP];
  logic [ADDR_W-1:0] cfg_sz   [NGRP];
  logic [NGRP-1:0]   cfg_open = '0, cfg_close = '0;
  logic [NGRP*CNT_W-1:0]  grp_count;
  logic [NGRP*ADDR_W-1:0] grp_size;
  logic bus_req_valid, bus_req_write;
  logic bus_req_ready = 1'b0;
  logic [ADDR_W-1:0] bus_req_addr;
  logic [15:0] bus_req_wdata;
  logic bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
  logic [15:0] bus_rsp_rdata = '0;
  logic rec_valid, rec_locked, rec_ready = 1'b0;
  logic [ADDR_W-1:0] rec_offset;
  logic done, done_pass, done_err;

  for (genvar g = 0; g < NGRP; g++) begin : g_pack
    assign grp_count[g*CNT_W +: CNT_W]  = cfg_cnt[g];
    assign grp_size[g*ADDR_W +: ADDR_W] = cfg_sz[g];
  end

  flash_lock_scanner #(.ADDR_W(ADDR_W), .NGRP(NGRP), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
    .verify_target(verify_target), .base_addr(BASE), .grp_used(grp_used),
    .grp_count(grp_count), .grp_size(grp_size), .grp_open(cfg_open),
    .grp_close(cfg_close), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_req_write(bus_req_write),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
    .bus_rsp_err(bus_rsp_err), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_offset(rec_offset), .rec_locked(rec_locked), .done(done),
    .done_pass(done_pass), .done_err(done_err)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int lock_mode = 0, fail_off = 0, err_idx = -1;
  int bus_mod = 1, rec_mod = 1;

  logic [ADDR_W-1:0] act_a[$], exp_a[$], act_ro[$], exp_ro[$];
  logic [15:0]       act_d[$], exp_d[$];
  logic              act_w[$], exp_w[$], act_rl[$], exp_rl[$];
  bit hold_prev = 0;
  logic [ADDR_W-1:0] hold_off;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit lock_of(int unsigned off);
    case (lock_mode)
      0:       return ((off >> 12) % 3) == 1;
      1:       return 1'b1;
      2:       return off != fail_off;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // flash responder: one access at a time, response one cycle after accept
  initial begin
    bit pend = 0; int n = 0;
    logic [15:0] rd; bit er;
    forever begin
      @(negedge clk);
      bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0;
      if (pend) begin
        bus_rsp_valid = 1'b1; bus_rsp_rdata = rd; bus_rsp_err = er; pend = 0;
      end
      bus_req_ready = !pend && ((bus_mod <= 1) || (cyc % bus_mod) != 0);
      #1;
      if (bus_req_valid && bus_req_ready) begin
        act_a.push_back(bus_req_addr); act_d.push_back(bus_req_wdata);
        act_w.push_back(bus_req_write);
        rd = 16'hA5A4 | 16'(lock_of(int'(bus_req_addr - BASE - 24'd4)));
        er = (n == err_idx);
        n++; pend = 1;
      end
      if (!rst_n) n = 0;
      if (act_a.size() == 0) n = 0;
    end
  end

  // record sink with back-pressure and hold check (R6)
  initial begin
    forever begin
      @(negedge clk);
      rec_ready = (rec_mod <= 1) || (cyc % rec_mod) == 0;
      #1;
      if (hold_prev)
        check(rec_valid && rec_offset == hold_off, "R6", "stalled record held",
              rec_offset, hold_off);
      if (hold_prev && bus_req_valid)
        check(1'b0, "R6", "bus request during stall", 1, 0);
      hold_prev = rec_valid && !rec_ready;
      hold_off  = rec_offset;
      if (rec_valid && rec_ready) begin
        act_ro.push_back(rec_offset); act_rl.push_back(rec_locked);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  function automatic bit build_expected(bit ver, bit tgt);
    int unsigned off = 0;
    logic [ADDR_W-1:0] pb = BASE;
    exp_a.delete(); exp_d.delete(); exp_w.delete(); exp_ro.delete(); exp_rl.delete();
    for (int g = 0; g < int'(grp_used); g++) begin
      if (cfg_open[g]) begin
        pb = BASE + ADDR_W'(off);
        exp_a.push_back(pb + 24'hAAA); exp_d.push_back(16'h00AA); exp_w.push_back(1);
        exp_a.push_back(pb + 24'h554); exp_d.push_back(16'h0055); exp_w.push_back(1);
        exp_a.push_back(pb + 24'hAAA); exp_d.push_back(16'h0090); exp_w.push_back(1);
      end
      for (int b = 0; b < int'(cfg_cnt[g]); b++) begin
        bit l = lock_of(off);
        exp_a.push_back(BASE + ADDR_W'(off) + 24'd4); exp_d.push_back(16'h0); exp_w.push_back(0);
        exp_ro.push_back(ADDR_W'(off)); exp_rl.push_back(l);
        if (ver && l != tgt) begin
          exp_a.push_back(pb + 24'hAAA); exp_d.push_back(16'h00F0); exp_w.push_back(1);
          return 0;
        end
        off += int'(cfg_sz[g]);
      end
      if (cfg_close[g]) begin
        exp_a.push_back(pb + 24'hAAA); exp_d.push_back(16'h00F0); exp_w.push_back(1);
      end
    end
    return 1;
  endfunction

  task automatic run_scan(input bit ver, input bit tgt, input bit extra,
                          output bit got_done, output bit p, output bit e);
    act_a.delete(); act_d.delete(); act_w.delete(); act_ro.delete(); act_rl.delete();
    got_done = 0; p = 0; e = 0;
    @(negedge clk); verify_en = ver; verify_target = tgt; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (extra && i == 15) start = 1'b1;
      if (extra && i == 16) start = 1'b0;
      if (done) begin got_done = 1; p = done_pass; e = done_err; break; end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_logs(input string req);
    check(act_a.size() == exp_a.size(), req, "access count", act_a.size(), exp_a.size());
    for (int i = 0; i < act_a.size() && i < exp_a.size(); i++) begin
      bit ok = act_a[i] == exp_a[i] && act_w[i] == exp_w[i] &&
               (!exp_w[i] || act_d[i] == exp_d[i]);
      check(ok, req, $sformatf("access %0d addr", i), act_a[i], exp_a[i]);
      if (!ok) break;
    end
    check(act_ro.size() == exp_ro.size(), req, "record count", act_ro.size(), exp_ro.size());
    for (int i = 0; i < act_ro.size() && i < exp_ro.size(); i++) begin
      bit ok = act_ro[i] == exp_ro[i] && act_rl[i] == exp_rl[i];
      check(ok, req, $sformatf("record %0d off/lock", i),
            {act_ro[i], 3'b0, act_rl[i]}, {exp_ro[i], 3'b0, exp_rl[i]});
      if (!ok) break;
    end
  endtask

  task automatic cfg_a();
    cfg_cnt[0] = 4; cfg_sz[0] = 24'h1000;
    cfg_cnt[1] = 2; cfg_sz[1] = 24'h4000;
    cfg_cnt[2] = 3; cfg_sz[2] = 24'h2000;
    cfg_cnt[3] = 5; cfg_sz[3] = 24'h0100;
    cfg_open = 4'b0101; cfg_close = 4'b0110; grp_used = 3;
  endtask

  task automatic t_reset();
    check(!bus_req_valid && !rec_valid && !done, "R1", "idle after reset",
          {bus_req_valid, rec_valid, done}, 0);
  endtask

  task automatic t_scan_basic();
    bit d, p, e, xp;
    cfg_a(); lock_mode = 0; bus_mod = 1; rec_mod = 1;
    xp = build_expected(0, 0);
    run_scan(0, 0, 0, d, p, e);
    check(d && p && !e, "R9", "plain scan done flags", {d, p, e}, {1'b1, xp, 1'b0});
    compare_logs("R2 R3 R4 R5");
  endtask

  task automatic t_backpressure();
    bit d, p, e, xp;
    cfg_a(); lock_mode = 0; bus_mod = 3; rec_mod = 4;
    xp = build_expected(0, 0);
    run_scan(0, 0, 0, d, p, e);
    check(d && p == xp && !e, "R7", "stalled scan done", {d, p, e}, {1'b1, xp, 1'b0});
    compare_logs("R6 R7");
    bus_mod = 1; rec_mod = 1;
  endtask

  task automatic t_verify_pass();
    bit d, p, e;
    cfg_a(); lock_mode = 1;
    void'(build_expected(1, 1));
    run_scan(1, 1, 0, d, p, e);
    check(d && p && !e, "R9", "check mode all match", {d, p, e}, 3'b110);
    compare_logs("R9");
  endtask

  task automatic t_verify_fail();
    bit d, p, e;
    cfg_a(); lock_mode = 2; fail_off = 32'h8000; rec_mod = 2;
    void'(build_expected(1, 1));
    run_scan(1, 1, 0, d, p, e);
    check(d && !p && !e, "R8", "mismatch ends failed", {d, p, e}, 3'b100);
    compare_logs("R8");
    rec_mod = 1;
  endtask

  task automatic t_bus_error();
    bit d, p, e;
    cfg_a(); lock_mode = 0; err_idx = 5;
    run_scan(0, 0, 0, d, p, e);
    check(d && !p && e, "R10", "error done flags", {d, p, e}, 3'b101);
    check(act_a.size() == 6, "R10", "accesses after error", act_a.size(), 6);
    check(act_ro.size() == 2, "R10", "records after error", act_ro.size(), 2);
    err_idx = -1;
  endtask

  task automatic t_restart_ignored();
    bit d, p, e;
    cfg_a(); lock_mode = 0;
    void'(build_expected(0, 0));
    run_scan(0, 0, 1, d, p, e);
    check(d && p && !e, "R11", "restart ignored done", {d, p, e}, 3'b110);
    compare_logs("R11");
    check(!bus_req_valid && !rec_valid, "R11", "quiet after scan", bus_req_valid, 0);
  endtask

  task automatic t_zero_count();
    bit d, p, e;
    cfg_cnt[0] = 0; cfg_sz[0] = 24'h1000;
    cfg_cnt[1] = 2; cfg_sz[1] = 24'h0800;
    cfg_open = 4'b0011; cfg_close = 4'b0011; grp_used = 2; lock_mode = 0;
    void'(build_expected(0, 0));
    run_scan(0, 0, 0, d, p, e);
    check(d && p && !e, "R12", "zero-count scan done", {d, p, e}, 3'b110);
    compare_logs("R12");
    check(act_ro.size() == 2 && act_ro[0] == 0, "R12", "first record offset",
          act_ro.size(), 2);
  endtask

  initial begin
    for (int g = 0; g < NGRP; g++) begin cfg_cnt[g] = '0; cfg_sz[g] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan_basic();
    t_backpressure();
    t_verify_pass();
    t_verify_fail();
    t_bus_error();
    t_restart_ignored();
    t_zero_count();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule